// File: doc/BRIEF.md
# Flash Word SECDED Guard with Fetch/Load Error Routing

This block sits between a flash array and the rest of the chip, protecting each 32-bit flash word with a 39-bit single-error-correct, double-error-detect code. On the write side it encodes a data word into the codeword that gets stored. This path is purely combinational. On the read side it takes a raw codeword and a tag. The tag says whether the read is an instruction fetch or a data load. One clock later the block returns the repaired data word and a class: clean, erased, corrected, or uncorrectable.

The result of each read is recorded in one of two sticky three-flag status sets, chosen by the access tag. Software clears these flags by write-one-to-clear pulses. Each flag has its own enable that lets it drive the shared maskable interrupt. A fetch that reads an erased or uncorrectable word also produces a one-cycle non-maskable interrupt pulse, because the program itself cannot be trusted. Loads never produce that pulse.

The read pipeline is a two-state machine. PIPE_IDLE holds when no read was presented and the response is not valid. PIPE_HOLD holds for the cycle after a read, with the response valid. Transitions: IDLE→HOLD on a read (accept), HOLD→HOLD on a back-to-back read (stream), HOLD→IDLE when no read follows (drain), IDLE→IDLE otherwise (wait).

Top module: `flash_ecc_guard`

## Requirements
- R1: The codeword is laid out as follows. Bit positions 1, 2, 4, 8, 16 and 32 hold Hamming check bits. The data bits fill the remaining positions 3, 5, 6, 7, 9 to 15, 17 to 31 and 33 to 38, in ascending order from data bit 0. The check bit at position 2^k is the even parity of all positions 1..38 whose index has bit k set. Bit 0 makes the parity of all 39 bits even.
- R2: A read presented on rd_valid produces rsp_valid exactly in the following cycle. A valid codeword there gives class 0 (clean) and its data.
- R3: A raw codeword of all 39 ones is classed 1 (erased) before any decode, and returns data of all ones.
- R4: Any single flipped bit, at any of the 39 positions, is repaired. The block returns the original data with class 2 (corrected).
- R5: Any two flipped bits give class 3 (uncorrectable).
- R6: Each read sets one flag, in stat_fetch when rd_fetch is 1 and in stat_load otherwise. Bit 0 is erased, bit 1 is corrected and bit 2 is uncorrectable. A clean read sets no flag. Flags stay set until cleared.
- R7: A one on clr_fetch or clr_load clears that flag at the next edge. A set arriving in the same cycle wins over the clear.
- R8: irq is high exactly when some flag is set and its enable bit (same bit position in irq_en_fetch or irq_en_load) is high.
- R9: nmi is high for exactly the one cycle after a fetch classed erased or uncorrectable. It stays low for loads and for clean or corrected fetches, whatever the enables are.
- R10: After reset all flags are zero, and rsp_valid, irq and nmi are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 32 | Data word to encode |
| wr_code | output | 39 | Encoded codeword for storage |
| rd_valid | input | 1 | Read codeword present this cycle |
| rd_fetch | input | 1 | 1 = instruction fetch, 0 = data load |
| rd_code | input | 39 | Raw codeword from the array |
| rsp_valid | output | 1 | Response valid (one cycle after read) |
| rsp_data | output | 32 | Repaired data word |
| rsp_class | output | 2 | 0 clean, 1 erased, 2 corrected, 3 uncorrectable |
| clr_fetch | input | 3 | Write-one-to-clear for fetch flags |
| clr_load | input | 3 | Write-one-to-clear for load flags |
| irq_en_fetch | input | 3 | Interrupt enables for fetch flags |
| irq_en_load | input | 3 | Interrupt enables for load flags |
| stat_fetch | output | 3 | Sticky fetch flags {uncorr, corrected, erased} |
| stat_load | output | 3 | Sticky load flags {uncorr, corrected, erased} |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt pulse |

## Verification
The assertions rely on rd_fetch being meaningful only while rd_valid is high. They also rely on the clear inputs being single-cycle pulses from software and never held so as to fight a set. The bench drives every input at the falling edge and pulses each clear for exactly one cycle. It presents only codewords built from a known word with zero, one or two chosen bit flips, or the all-ones pattern. This means every read falls in a class the reference model can decide by brute-force search.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;
    localparam int DATA_W  = 32;
    localparam int HAM_W   = 6;
    localparam int CW_W    = DATA_W + HAM_W + 1;
    localparam int TOP_POS = CW_W - 1;
    localparam int NFLAG   = 3;

    localparam int FLG_ERASED = 0;
    localparam int FLG_CORR   = 1;
    localparam int FLG_UNCORR = 2;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_ERASED = 2'd1,
        CLS_CORR   = 2'd2,
        CLS_UNCORR = 2'd3
    } ecc_class_e;

    typedef enum logic {
        PIPE_IDLE = 1'b0,
        PIPE_HOLD = 1'b1
    } pipe_state_e;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Position in the codeword that carries data bit j.
    function automatic int data_pos(input int j);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= TOP_POS; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j) res = p;
                cnt++;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/flash_ecc_enc.sv
module flash_ecc_enc
    import flash_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   code
);
    logic [CW_W-1:0] placed;

    // Scatter data bits into non-power-of-two positions.
    genvar gj;
    generate
        for (gj = 0; gj < DATA_W; gj++) begin : g_place
            localparam int POS = data_pos(gj);
            assign placed[POS] = data[gj];
        end
        for (gj = 0; gj < HAM_W; gj++) begin : g_chk
            localparam int CPOS = 1 << gj;
            logic par;
            always_comb begin
                par = 1'b0;
                for (int p = 1; p <= TOP_POS; p++) begin
                    if (!is_pow2(p) && (((p >> gj) & 1) == 1)) par = par ^ placed[p];
                end
            end
            assign placed[CPOS] = par;
        end
    endgenerate

    assign placed[0] = ^placed[TOP_POS:1];
    assign code      = placed;
endmodule

// File: rtl/flash_ecc_dec.sv
module flash_ecc_dec
    import flash_ecc_pkg::*;
(
    input  logic [CW_W-1:0]   code,
    output logic [DATA_W-1:0] data,
    output ecc_class_e        cls
);
    logic [HAM_W-1:0] syn;
    logic             par;
    logic             erased;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= TOP_POS; p++) begin
            if (code[p]) syn = syn ^ HAM_W'(p);
        end
        par    = ^code;
        erased = &code;
        fixed  = code;
        cls    = CLS_CLEAN;
        if (erased) begin
            cls = CLS_ERASED;
        end else if (!par && syn == '0) begin
            cls = CLS_CLEAN;
        end else if (par) begin
            if (syn == '0) begin
                fixed[0] = ~code[0];
                cls      = CLS_CORR;
            end else if (int'(syn) <= TOP_POS) begin
                for (int p = 1; p <= TOP_POS; p++) begin
                    if (p == int'(syn)) fixed[p] = ~code[p];
                end
                cls = CLS_CORR;
            end else begin
                cls = CLS_UNCORR;
            end
        end else begin
            cls = CLS_UNCORR;
        end
        for (int j = 0; j < DATA_W; j++) data[j] = fixed[data_pos(j)];
    end
endmodule

// File: rtl/flash_ecc_route.sv
module flash_ecc_route
    import flash_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_fetch,
    input  ecc_class_e       ev_cls,
    input  logic [NFLAG-1:0] clr_fetch,
    input  logic [NFLAG-1:0] clr_load,
    input  logic [NFLAG-1:0] en_fetch,
    input  logic [NFLAG-1:0] en_load,
    output logic [NFLAG-1:0] stat_fetch,
    output logic [NFLAG-1:0] stat_load,
    output logic             irq,
    output logic             nmi
);
    logic [NFLAG-1:0] hit;
    logic [NFLAG-1:0] set_f;
    logic [NFLAG-1:0] set_l;
    logic             fatal;

    always_comb begin
        hit = '0;
        unique case (ev_cls)
            CLS_CLEAN:  hit = '0;
            CLS_ERASED: hit[FLG_ERASED] = 1'b1;
            CLS_CORR:   hit[FLG_CORR]   = 1'b1;
            CLS_UNCORR: hit[FLG_UNCORR] = 1'b1;
        endcase
        set_f = (ev_valid &&  ev_fetch) ? hit : '0;
        set_l = (ev_valid && !ev_fetch) ? hit : '0;
        fatal = ev_valid && ev_fetch && (hit[FLG_ERASED] || hit[FLG_UNCORR]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_fetch <= '0;
            stat_load  <= '0;
            nmi        <= 1'b0;
        end else begin
            stat_fetch <= (stat_fetch & ~clr_fetch) | set_f;
            stat_load  <= (stat_load  & ~clr_load)  | set_l;
            nmi        <= fatal;
        end
    end

    assign irq = (|(stat_fetch & en_fetch)) | (|(stat_load & en_load));

    AST_LOAD_NO_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_fetch) |=> !nmi); // R9
    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> $past(ev_valid && ev_fetch &&
                             (ev_cls == CLS_ERASED || ev_cls == CLS_UNCORR))); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_fetch[FLG_CORR] && !clr_fetch[FLG_CORR]) |=> stat_fetch[FLG_CORR]); // R6
    AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_load[FLG_UNCORR] && !clr_load[FLG_UNCORR]) |=> stat_load[FLG_UNCORR]); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_fetch && ev_cls == CLS_CORR) |=> stat_fetch[FLG_CORR]); // R7
endmodule

// File: rtl/flash_ecc_guard.sv
module flash_ecc_guard
    import flash_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW_W-1:0]   wr_code,
    input  logic              rd_valid,
    input  logic              rd_fetch,
    input  logic [CW_W-1:0]   rd_code,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_class,
    input  logic [NFLAG-1:0]  clr_fetch,
    input  logic [NFLAG-1:0]  clr_load,
    input  logic [NFLAG-1:0]  irq_en_fetch,
    input  logic [NFLAG-1:0]  irq_en_load,
    output logic [NFLAG-1:0]  stat_fetch,
    output logic [NFLAG-1:0]  stat_load,
    output logic              irq,
    output logic              nmi
);
    logic [DATA_W-1:0] dec_data;
    ecc_class_e        dec_cls;
    pipe_state_e       state_q;
    pipe_state_e       state_d;
    logic [DATA_W-1:0] data_q;
    ecc_class_e        cls_q;

    flash_ecc_enc u_enc (.data(wr_data), .code(wr_code));

    flash_ecc_dec u_dec (.code(rd_code), .data(dec_data), .cls(dec_cls));

    flash_ecc_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (rd_valid),
        .ev_fetch  (rd_fetch),
        .ev_cls    (dec_cls),
        .clr_fetch (clr_fetch),
        .clr_load  (clr_load),
        .en_fetch  (irq_en_fetch),
        .en_load   (irq_en_load),
        .stat_fetch(stat_fetch),
        .stat_load (stat_load),
        .irq       (irq),
        .nmi       (nmi)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIPE_IDLE: state_d = rd_valid ? PIPE_HOLD : PIPE_IDLE;
            PIPE_HOLD: state_d = rd_valid ? PIPE_HOLD : PIPE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIPE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cls_q  <= CLS_CLEAN;
        end else if (rd_valid) begin
            data_q <= dec_data;
            cls_q  <= dec_cls;
        end
    end

    assign rsp_valid = (state_q == PIPE_HOLD);
    assign rsp_data  = data_q;
    assign rsp_class = cls_q;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid); // R2
    AST_RSP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rsp_valid); // R2
    AST_ERASED_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (&rd_code)) |=> (rsp_class == CLS_ERASED)); // R3
endmodule

// File: tb/sim_flash_ecc_guard.sv
module sim_flash_ecc_guard;
    localparam int DW = 32;
    localparam int CW = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] wr_code;
    logic          rd_valid = 1'b0;
    logic          rd_fetch = 1'b0;
    logic [CW-1:0] rd_code = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [1:0]    rsp_class;
    logic [2:0]    clr_fetch = '0;
    logic [2:0]    clr_load = '0;
    logic [2:0]    irq_en_fetch = '0;
    logic [2:0]    irq_en_load = '0;
    logic [2:0]    stat_fetch;
    logic [2:0]    stat_load;
    logic          irq;
    logic          nmi;

    int n_vec = 0;
    int n_bad = 0;
    logic [2:0] m_sf = '0;
    logic [2:0] m_sl = '0;

    always #10 clk = ~clk;

    flash_ecc_guard u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pw2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p < CW; p++) if (!pw2(p)) begin c[p] = d[j]; j++; end
        for (int k = 0; k < 6; k++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW; p++) if (((p >> k) & 1) == 1 && p != (1 << k)) x ^= c[p];
            c[1 << k] = x;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] ref_ext(input logic [CW-1:0] c);
        logic [DW-1:0] d;
        int j;
        j = 0;
        d = '0;
        for (int p = 1; p < CW; p++) if (!pw2(p)) begin d[j] = c[p]; j++; end
        return d;
    endfunction

    // Brute-force classification: 0 clean, 1 erased, 2 corrected, 3 uncorrectable.
    task automatic ref_dec(input logic [CW-1:0] c, output int cls, output logic [DW-1:0] d);
        cls = 3;
        d = ref_ext(c);
        if (&c) begin cls = 1; d = '1; end
        else if (ref_enc(ref_ext(c)) == c) cls = 0;
        else begin
            for (int i = 0; i < CW; i++) begin
                logic [CW-1:0] t;
                t = c;
                t[i] = ~t[i];
                if (cls == 3 && ref_enc(ref_ext(t)) == t) begin cls = 2; d = ref_ext(t); end
            end
        end
    endtask

    // One clock: drive at falling edge, compare at the next falling edge.
    task automatic cyc(input string req, input logic v, input logic f,
                       input logic [CW-1:0] c, input logic [2:0] cf, input logic [2:0] cl);
        int cls;
        logic [DW-1:0] d;
        logic [2:0] hit;
        logic e_nmi;
        rd_valid = v; rd_fetch = f; rd_code = c; clr_fetch = cf; clr_load = cl;
        ref_dec(c, cls, d);
        hit = '0;
        if (cls != 0) hit[cls-1] = 1'b1;
        e_nmi = v && f && (cls == 1 || cls == 3);
        m_sf = (m_sf & ~cf) | ((v && f) ? hit : 3'b0);
        m_sl = (m_sl & ~cl) | ((v && !f) ? hit : 3'b0);
        @(negedge clk);
        rd_valid = 1'b0; clr_fetch = '0; clr_load = '0;
        chk({req, " rsp_valid"}, 64'(rsp_valid), 64'(v));
        if (v) begin
            chk({req, " class"}, 64'(rsp_class), 64'(cls));
            if (cls != 3) chk({req, " data"}, 64'(rsp_data), 64'(d));
        end
        chk({req, " R9 nmi"}, 64'(nmi), 64'(e_nmi));
        chk({req, " R6 stat_fetch"}, 64'(stat_fetch), 64'(m_sf));
        chk({req, " R6 stat_load"}, 64'(stat_load), 64'(m_sl));
        chk({req, " R8 irq"}, 64'(irq),
            64'((|(m_sf & irq_en_fetch)) | (|(m_sl & irq_en_load))));
    endtask

    function automatic logic [CW-1:0] flip2(input logic [CW-1:0] c, input int a, input int b);
        logic [CW-1:0] t;
        t = c;
        t[a] = ~t[a];
        t[b] = ~t[b];
        return t;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] words [4];
        logic [CW-1:0] cw;
        words[0] = 32'h0000_0000;
        words[1] = 32'hFFFF_FFFF;
        words[2] = 32'hA5C3_1E69;
        words[3] = 32'h8000_0001;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 stat_fetch", 64'(stat_fetch), 64'd0);
        chk("R10 stat_load", 64'(stat_load), 64'd0);
        chk("R10 irq", 64'(irq), 64'd0);
        chk("R10 nmi", 64'(nmi), 64'd0);
        chk("R10 rsp_valid", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 encoder layout
        for (int i = 0; i < 4; i++) begin
            wr_data = words[i];
            #1;
            chk("R1 encode", 64'(wr_code), 64'(ref_enc(words[i])));
        end
        for (int k = 0; k < DW; k += 5) begin
            wr_data = 32'h1 << k;
            #1;
            chk("R1 encode walk", 64'(wr_code), 64'(ref_enc(32'h1 << k)));
        end
        @(negedge clk);

        irq_en_fetch = 3'b111;
        irq_en_load = 3'b111;

        // R2 clean reads, back to back
        for (int i = 0; i < 4; i++) cyc("R2 clean", 1'b1, i[0], ref_enc(words[i]), 3'b0, 3'b0);
        cyc("R2 idle", 1'b0, 1'b0, '0, 3'b0, 3'b0);

        // R4 every single-bit flip on fetch
        cw = ref_enc(words[2]);
        for (int i = 0; i < CW; i++) begin
            logic [CW-1:0] t;
            t = cw;
            t[i] = ~t[i];
            cyc("R4 single", 1'b1, 1'b1, t, 3'b0, 3'b0);
        end
        // R7 clear the corrected flag
        cyc("R7 clear", 1'b0, 1'b0, '0, 3'b010, 3'b0);
        // R7 set wins over clear
        cw = ref_enc(words[3]);
        cyc("R7 set wins", 1'b1, 1'b1, cw ^ 39'h1_0000_0000, 3'b010, 3'b0);

        // R5 double errors on fetch; R9 nmi pulse then low
        cyc("R5 double", 1'b1, 1'b1, flip2(ref_enc(words[2]), 0, 7), 3'b0, 3'b0);
        cyc("R9 pulse end", 1'b0, 1'b0, '0, 3'b0, 3'b0);
        cyc("R5 double2", 1'b1, 1'b1, flip2(ref_enc(words[1]), 3, 38), 3'b0, 3'b0);
        cyc("R5 double3", 1'b1, 1'b1, flip2(ref_enc(words[0]), 1, 2), 3'b0, 3'b0);

        // R3 erased fetch then load
        cyc("R3 erased fetch", 1'b1, 1'b1, '1, 3'b0, 3'b0);
        cyc("R3 erased load", 1'b1, 1'b0, '1, 3'b0, 3'b0);

        // R9 loads never pulse nmi
        cyc("R9 load double", 1'b1, 1'b0, flip2(ref_enc(words[3]), 5, 30), 3'b0, 3'b0);
        cyc("R9 load single", 1'b1, 1'b0, ref_enc(words[3]) ^ 39'h8, 3'b0, 3'b0);

        // R8 enables gate the irq; flags remain set
        irq_en_fetch = 3'b000;
        irq_en_load = 3'b000;
        cyc("R8 all masked", 1'b0, 1'b0, '0, 3'b0, 3'b0);
        irq_en_load = 3'b010;
        cyc("R8 one enable", 1'b0, 1'b0, '0, 3'b0, 3'b0);
        cyc("R7 clear load", 1'b0, 1'b0, '0, 3'b0, 3'b010);
        cyc("R7 clear fetch all", 1'b0, 1'b0, '0, 3'b111, 3'b111);
        irq_en_fetch = 3'b111;
        cyc("R8 nothing pending", 1'b0, 1'b0, '0, 3'b0, 3'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule